// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block merges the interrupt sources of a serial port receiver and transmitter into one prioritised identification code and one interrupt request line. It watches four conditions: a receive error, the receive queue filling to its trigger level, data left idle in the receive queue, and the transmit holding stage becoming empty. It gates each condition with its enable bit and reports the most urgent active one. The serial shifters, the queue storage and the register decoding sit outside it. The surrounding logic supplies the queue fill level, the error events, a tick once per character time, and strobes for reads of the status and identification registers and for writes of the transmit register.

Two of the sources are remembered until they are serviced. The line-status source stays pending until the status register is read. The transmit-empty source stays pending until the transmit register is written, or until the identification register is read while it is the source being reported. The other two sources follow live conditions. The data-available source tracks the fill level against the trigger level. The idle-timeout source uses a character-time counter that any queue activity restarts.

Top module: `uart_irq_ident`

## Requirements
- R1: `intId[0]` is active low: 0 means an interrupt is pending and 1 means none is. `intPending` and `irq` are high exactly when `intId[0]` is 0. After reset `intId` is 4'b0001.
- R2: `intId[3:1]` gives the reported source as 3'b011 line status, 3'b010 data available, 3'b110 idle timeout, 3'b001 transmit empty, 3'b000 none. When several sources are active the priority is line status, then data available, then idle timeout, then transmit empty.
- R3: `irqEnable[0]` enables data available and idle timeout, `irqEnable[1]` enables transmit empty, and `irqEnable[2]` enables line status. A latched source stays latched while its enable is off and is reported as soon as its enable is set.
- R4: A pulse on `rxErr` latches the line-status source. A pulse on `lsrRead` clears it. If both arrive in the same cycle, the source stays latched.
- R5: Data available is active while `rxLevel` is at or above the trigger level. `trigSel` codes 0, 1, 2 and 3 select trigger levels of 1, 4, 8 and 14 entries.
- R6: Idle timeout becomes active once `rxLevel` is nonzero and 4 `charTick` pulses have arrived with no `rxPush` or `rxPop`. A push, a pop or an empty queue clears it and restarts the count.
- R7: A rising edge of `txEmpty` latches the transmit-empty source. It is cleared by `thrWrite`, or by `iirRead` in a cycle in which `intId[3:1]` is 3'b001.
- R8: An `iirRead` while another source is being reported leaves a latched transmit-empty source pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqEnable | input | 3 | Source enables (bit 0 data/timeout, bit 1 transmit empty, bit 2 line status) |
| rxErr | input | 1 | Receive error event, one cycle |
| rxLevel | input | 5 | Receive queue fill level |
| trigSel | input | 2 | Receive trigger level select |
| charTick | input | 1 | One pulse per character time |
| rxPush | input | 1 | Character written into the receive queue |
| rxPop | input | 1 | Character read from the receive queue |
| txEmpty | input | 1 | Transmit holding stage empty |
| lsrRead | input | 1 | Line status register read strobe |
| iirRead | input | 1 | Identification register read strobe |
| thrWrite | input | 1 | Transmit register write strobe |
| intId | output | 4 | Identification code |
| intPending | output | 1 | Interrupt pending flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `rxErr`, `rxPush`, `rxPop`, `charTick` and the three access strobes are single-cycle pulses. They also assume that `rxLevel` never exceeds the queue depth, and that a push or pop is the only thing that changes the level while the timeout count runs. The stimulus pulses each strobe for exactly one cycle. It keeps `rxLevel` within 0 to 16, and it changes `rxLevel`, `trigSel` and `irqEnable` only on the falling clock edge, where the unit treats them as steady levels.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [2:0] {
    SRC_NONE = 3'b000,
    SRC_THRE = 3'b001,
    SRC_RDA  = 3'b010,
    SRC_LS   = 3'b011,
    SRC_CTO  = 3'b110
  } srcCode_e;

  typedef struct packed {
    logic setLs;
    logic clrLs;
    logic setThre;
    logic clrThre;
    logic clrIdle;
    logic tickIdle;
  } ctlStrobes_t;

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxErr,
  input  logic        lsrRead,
  input  logic        txEmpty,
  input  logic        thrWrite,
  input  logic        iirRead,
  input  logic        rxPush,
  input  logic        rxPop,
  input  logic        charTick,
  input  srcCode_e    reportedSrc,
  output ctlStrobes_t strobes
);

  logic txEmptyQ;

  // held high in reset so an already-empty stage raises nothing on release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txEmptyQ <= 1'b1;
    else       txEmptyQ <= txEmpty;
  end

  always_comb begin
    strobes.setLs    = rxErr;
    strobes.clrLs    = lsrRead;
    strobes.setThre  = txEmpty && !txEmptyQ;
    strobes.clrThre  = thrWrite || (iirRead && reportedSrc == SRC_THRE);
    strobes.clrIdle  = rxPush || rxPop;
    strobes.tickIdle = charTick;
  end

  // R7
  thre_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setThre |-> $rose(txEmpty));

endmodule

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
#(
  parameter int LEVEL_W  = 5,
  parameter int TO_TICKS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic [1:0]         trigSel,
  input  logic [2:0]         irqEnable,
  output srcCode_e           reportedSrc,
  output logic [3:0]         intId
);

  localparam int CNT_W = $clog2(TO_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(TO_TICKS);

  logic             lsPend;
  logic             threPend;
  logic [CNT_W-1:0] idleCnt;
  logic [LEVEL_W-1:0] trigLevel;
  logic             rdaCond;
  logic             ctoCond;
  logic             queueEmpty;

  assign queueEmpty = (rxLevel == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lsPend   <= 1'b0;
      threPend <= 1'b0;
      idleCnt  <= '0;
    end else begin
      if (strobes.setLs)        lsPend <= 1'b1;
      else if (strobes.clrLs)   lsPend <= 1'b0;

      if (strobes.clrThre)      threPend <= 1'b0;
      else if (strobes.setThre) threPend <= 1'b1;

      if (strobes.clrIdle || queueEmpty)
        idleCnt <= '0;
      else if (strobes.tickIdle && idleCnt != CNT_FULL)
        idleCnt <= idleCnt + 1'b1;
    end
  end

  always_comb begin
    case (trigSel)
      2'd0:    trigLevel = LEVEL_W'(1);
      2'd1:    trigLevel = LEVEL_W'(4);
      2'd2:    trigLevel = LEVEL_W'(8);
      default: trigLevel = LEVEL_W'(14);
    endcase
  end

  assign rdaCond = (rxLevel >= trigLevel);
  assign ctoCond = (idleCnt == CNT_FULL) && !queueEmpty;

  always_comb begin
    if (irqEnable[2] && lsPend)         reportedSrc = SRC_LS;
    else if (irqEnable[0] && rdaCond)   reportedSrc = SRC_RDA;
    else if (irqEnable[0] && ctoCond)   reportedSrc = SRC_CTO;
    else if (irqEnable[1] && threPend)  reportedSrc = SRC_THRE;
    else                                reportedSrc = SRC_NONE;
  end

  assign intId = {reportedSrc, reportedSrc == SRC_NONE};

  // R4
  ls_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrLs && !strobes.setLs) |=> !lsPend);

  // R2
  ls_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setLs |=> (!irqEnable[2] || reportedSrc == SRC_LS));

  // R7
  thre_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrThre |=> !threPend);

  // R6
  cto_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrIdle |=> reportedSrc != SRC_CTO);

  // R6
  cto_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    reportedSrc == SRC_CTO |-> !queueEmpty);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TO_TICKS   = 4,
  localparam int LEVEL_W   = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         irqEnable,
  input  logic               rxErr,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic [1:0]         trigSel,
  input  logic               charTick,
  input  logic               rxPush,
  input  logic               rxPop,
  input  logic               txEmpty,
  input  logic               lsrRead,
  input  logic               iirRead,
  input  logic               thrWrite,
  output logic [3:0]         intId,
  output logic               intPending,
  output logic               irq
);

  ctlStrobes_t strobes;
  srcCode_e    reportedSrc;

  uart_irq_ctrl ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .rxErr       (rxErr),
    .lsrRead     (lsrRead),
    .txEmpty     (txEmpty),
    .thrWrite    (thrWrite),
    .iirRead     (iirRead),
    .rxPush      (rxPush),
    .rxPop       (rxPop),
    .charTick    (charTick),
    .reportedSrc (reportedSrc),
    .strobes     (strobes)
  );

  uart_irq_datapath #(
    .LEVEL_W  (LEVEL_W),
    .TO_TICKS (TO_TICKS)
  ) dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .rxLevel     (rxLevel),
    .trigSel     (trigSel),
    .irqEnable   (irqEnable),
    .reportedSrc (reportedSrc),
    .intId       (intId)
  );

  assign intPending = !intId[0];
  assign irq        = !intId[0];

  // R3
  gate_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable == 3'b000) |-> !irq);

endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] irqEnable = 3'b000;
  logic       rxErr = 1'b0;
  logic [4:0] rxLevel = '0;
  logic [1:0] trigSel = '0;
  logic       charTick = 1'b0;
  logic       rxPush = 1'b0;
  logic       rxPop = 1'b0;
  logic       txEmpty = 1'b0;
  logic       lsrRead = 1'b0;
  logic       iirRead = 1'b0;
  logic       thrWrite = 1'b0;
  logic [3:0] intId;
  logic       intPending;
  logic       irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  uart_irq_ident uut (
    .clk(clk), .rstN(rstN), .irqEnable(irqEnable), .rxErr(rxErr),
    .rxLevel(rxLevel), .trigSel(trigSel), .charTick(charTick),
    .rxPush(rxPush), .rxPop(rxPop), .txEmpty(txEmpty),
    .lsrRead(lsrRead), .iirRead(iirRead), .thrWrite(thrWrite),
    .intId(intId), .intPending(intPending), .irq(irq)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // {trigSel, rxLevel, expected intId}; irqEnable = 3'b001, nothing else pending
  localparam logic [10:0] VEC [10] = '{
    {2'd0, 5'd0,  4'b0001}, {2'd0, 5'd1,  4'b0100},
    {2'd1, 5'd3,  4'b0001}, {2'd1, 5'd4,  4'b0100},
    {2'd2, 5'd7,  4'b0001}, {2'd2, 5'd8,  4'b0100},
    {2'd3, 5'd13, 4'b0001}, {2'd3, 5'd14, 4'b0100},
    {2'd3, 5'd16, 4'b0100}, {2'd1, 5'd0,  4'b0001}
  };

  task automatic check(input string req, input logic [3:0] exp);
    total++;
    if (intId !== exp || irq !== !exp[0] || intPending !== !exp[0]) begin
      bad++;
      $display("FAIL %s: actual intId=%b irq=%b pend=%b expected intId=%b",
               req, intId, irq, intPending, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) pulse(charTick);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset", 4'b0001);
    rstN = 1'b1;
    @(negedge clk) #1;
    check("R1 after release", 4'b0001);

    // R5 trigger level table
    irqEnable = 3'b001;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      trigSel = VEC[i][10:9];
      rxLevel = VEC[i][8:4];
      #1;
      check($sformatf("R5 vec%0d", i), VEC[i][3:0]);
    end

    // R4 / R2 line status over data available
    @(negedge clk) irqEnable = 3'b111; trigSel = 2'd0; rxLevel = 5'd1;
    #1 check("R2 rda alone", 4'b0100);
    pulse(rxErr);
    check("R2 R4 ls over rda", 4'b0110);
    @(negedge clk) rxErr = 1'b1; lsrRead = 1'b1;
    @(negedge clk) rxErr = 1'b0; lsrRead = 1'b0;
    #1 check("R4 set wins", 4'b0110);
    pulse(lsrRead);
    check("R4 cleared by read", 4'b0100);

    // R3 latched while disabled
    @(negedge clk) irqEnable = 3'b001;
    pulse(rxErr);
    check("R3 ls masked", 4'b0100);
    @(negedge clk) irqEnable = 3'b101;
    #1 check("R3 ls shown on enable", 4'b0110);
    pulse(lsrRead);
    @(negedge clk) rxLevel = 5'd0;

    // R6 idle timeout
    @(negedge clk) irqEnable = 3'b001; trigSel = 2'd1; rxLevel = 5'd2;
    #1 check("R6 below trigger", 4'b0001);
    ticks(3);
    check("R6 three ticks", 4'b0001);
    ticks(1);
    check("R6 fourth tick", 4'b1100);
    pulse(rxPop);
    check("R6 pop clears", 4'b0001);
    ticks(4);
    check("R6 refire", 4'b1100);
    pulse(rxPush);
    check("R6 push clears", 4'b0001);
    @(negedge clk) rxLevel = 5'd0;
    ticks(5);
    check("R6 empty queue", 4'b0001);
    @(negedge clk) irqEnable = 3'b000; rxLevel = 5'd2;
    ticks(4);
    check("R3 timeout masked", 4'b0001);
    @(negedge clk) irqEnable = 3'b001;
    #1 check("R3 timeout on enable", 4'b1100);
    pulse(rxPop);
    @(negedge clk) rxLevel = 5'd0;

    // R7 transmit empty
    @(negedge clk) irqEnable = 3'b010; txEmpty = 1'b1;
    @(negedge clk) #1 check("R7 rise latches", 4'b0010);
    pulse(iirRead);
    check("R7 iir read clears", 4'b0001);
    @(negedge clk) txEmpty = 1'b0;
    @(negedge clk) txEmpty = 1'b1;
    @(negedge clk) #1 check("R7 second rise", 4'b0010);
    pulse(thrWrite);
    check("R7 write clears", 4'b0001);

    // R8 read while data available reported
    @(negedge clk) txEmpty = 1'b0;
    @(negedge clk) txEmpty = 1'b1; irqEnable = 3'b011; trigSel = 2'd1; rxLevel = 5'd4;
    @(negedge clk) #1 check("R2 rda over thre", 4'b0100);
    pulse(iirRead);
    @(negedge clk) rxLevel = 5'd0;
    #1 check("R8 thre survives", 4'b0010);
    pulse(thrWrite);
    check("R7 final clear", 4'b0001);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule